// File: doc/BRIEF.md
# Framed Serial Command Receiver

This block sits behind a UART receiver and turns its byte stream into command packets. Packets are framed by the byte 0xC0. Inside a frame, the two-byte escape pairs 0xDB 0xDC and 0xDB 0xDD stand for the data bytes 0xC0 and 0xDB. After unescaping, the first byte of a frame is the device address. Then come zero or more payload bytes, then one check byte computed over the payload.

Frames that carry another device's address are dropped without trace. For a frame that carries the local address, the payload bytes are forwarded to the command decoder as a stream marked with first and last flags. When the closing 0xC0 arrives, a one-cycle strobe tells the reply logic whether to answer with an acknowledge code or a reject code.

A frame that stays open too long is abandoned, so a lost closing marker cannot hold the receiver. The limit is a parameter counted in clock cycles. The payload stream carries only the bytes between the address and the check byte. Because the check byte can only be recognised when the closing marker arrives, each payload byte is held back by two received bytes.

Top module: `slip_rx`

## Requirements
- R1: 0xC0 opens and closes a frame. A 0xC0 received while waiting for a frame, or directly after an opening 0xC0, only (re)opens a frame and produces no packet. Data bytes received outside a frame produce no output.
- R2: Inside a frame, 0xDB 0xDC decodes to the data byte 0xC0 and 0xDB 0xDD decodes to 0xDB. This applies to the address, payload and check bytes alike.
- R3: The first decoded byte after the opening 0xC0 is the address. The frame is accepted only when bit 7 of that byte is 0 and bits 6:0 equal `dev_addr`. Any other frame produces no payload output and no reply, up to and including its closing 0xC0.
- R4: The payload bytes of an accepted frame leave on `pld_data`, in order, with `pld_valid`. `pld_sop` marks the first payload byte. `pld_eop` marks the last one, which is presented in the cycle after the edge that samples the closing 0xC0.
- R5: The check byte is a CRC-8 with polynomial 0x07 and initial value 0x00. It is processed MSB first and computed over the unescaped payload bytes, excluding the address.
- R6: In the cycle after the closing 0xC0 of an accepted frame is sampled, `rep_valid` pulses for one cycle. `rep_code` is 0x00 (acknowledge) when the check byte matches and 0x80 (reject) otherwise.
- R7: An escape byte followed by anything other than 0xDC or 0xDD makes the frame end with code 0x80. An escape byte followed by 0xC0 closes the frame with code 0x80.
- R8: An accepted frame with no byte between the address and the closing 0xC0 ends with code 0x80.
- R9: Let the address of an accepted frame be sampled at edge a. If the closing 0xC0 is sampled by edge a+TIMEOUT_CYC, the frame completes normally. Otherwise, at edge a+TIMEOUT_CYC the frame is discarded without a reply or `pld_eop`, and the receiver waits for a new frame; the next 0xC0 opens one.
- R10: During and directly after reset, `pld_valid`, `pld_sop`, `pld_eop` and `rep_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A received byte is present on `in_data` this cycle |
| in_data | input | DATA_W | Received byte |
| dev_addr | input | ADDR_W | Local device address |
| pld_valid | output | 1 | Payload byte present |
| pld_data | output | DATA_W | Payload byte |
| pld_sop | output | 1 | First payload byte of the frame |
| pld_eop | output | 1 | Last payload byte of the frame |
| rep_valid | output | 1 | One-cycle reply request |
| rep_code | output | DATA_W | 0x00 acknowledge, 0x80 reject; valid with `rep_valid` |

## Verification
Some properties are checked on every cycle by the assertions:
- a reply code is always one of the two legal values;
- a reply only ever follows a cycle spent inside an accepted frame;
- a frame for another address stays silent;
- first/last flags never appear without a payload byte;
- an escape never spans more than one byte;
- the open-frame timer never runs past its limit.

Other behaviours need the scenarios of the bench: the exact payload contents and their order, the checksum verdict, the decoding of escaped check bytes, and the precise cycle on which a slow frame is still accepted or already abandoned.

// File: rtl/slip_rx_pkg.sv
package slip_rx_pkg;

   localparam logic [7:0] FRM_MARK    = 8'hC0;
   localparam logic [7:0] FRM_ESC     = 8'hDB;
   localparam logic [7:0] FRM_ESC_MRK = 8'hDC;
   localparam logic [7:0] FRM_ESC_ESC = 8'hDD;
   localparam logic [7:0] RPL_ACK     = 8'h00;
   localparam logic [7:0] RPL_NACK    = 8'h80;

   typedef enum logic [1:0] {
      FR_IDLE,
      FR_ADDR,
      FR_RX,
      FR_SKIP
   } frame_state_e;

   // one decoded event per input byte
   typedef struct packed {
      logic       data;   // val carries a decoded data byte
      logic       mark;   // frame marker seen
      logic       bad;    // illegal escape pair
      logic [7:0] val;
   } dec_ev_t;

endpackage

// File: rtl/slip_rx_unstuff.sv
module slip_rx_unstuff
   import slip_rx_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       flush,
   input  logic       in_valid,
   input  logic [7:0] in_data,
   output dec_ev_t    ev
);

   logic esc_q;

   always_comb begin
      ev      = '0;
      ev.val  = in_data;
      if (in_valid) begin
         if (esc_q) begin
            unique case (in_data)
               FRM_ESC_MRK: begin ev.data = 1'b1; ev.val = FRM_MARK; end
               FRM_ESC_ESC: begin ev.data = 1'b1; ev.val = FRM_ESC;  end
               FRM_MARK:    begin ev.mark = 1'b1; ev.bad = 1'b1;     end
               default:     ev.bad = 1'b1;
            endcase
         end else if (in_data == FRM_MARK) begin
            ev.mark = 1'b1;
         end else if (in_data != FRM_ESC) begin
            ev.data = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         esc_q <= 1'b0;
      else if (flush)
         esc_q <= 1'b0;
      else if (in_valid)
         esc_q <= !esc_q && (in_data == FRM_ESC);
   end

   // R2: an escape consumes exactly the next byte
   a_r2_escape_single: assert property (@(posedge clk) disable iff (!rst_n)
      (esc_q && in_valid) |=> !esc_q);

endmodule

// File: rtl/slip_rx_crc8.sv
module slip_rx_crc8 #(
   parameter int             W    = 8,
   parameter logic [W-1:0]   POLY = 8'h07
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         upd,
   input  logic [W-1:0] din,
   output logic [W-1:0] crc
);

   logic [W-1:0] crc_q;
   logic [W-1:0] stage [W+1];

   if (W < 2) begin : g_bad_width
      $error("slip_rx_crc8: W must be at least 2");
   end

   assign stage[0] = crc_q ^ din;

   for (genvar i = 0; i < W; i++) begin : g_bit
      assign stage[i+1] = stage[i][W-1] ? ((stage[i] << 1) ^ POLY) : (stage[i] << 1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         crc_q <= '0;
      else if (clr)
         crc_q <= '0;
      else if (upd)
         crc_q <= stage[W];
   end

   assign crc = crc_q;

endmodule

// File: rtl/slip_rx_timer.sv
module slip_rx_timer #(
   parameter int LIMIT = 25_000_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic stop,
   output logic expire
);

   localparam int CW = $clog2(LIMIT + 1);
   localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

   logic [CW-1:0] cnt_q;
   logic          run_q;

   if (LIMIT < 2) begin : g_bad_limit
      $error("slip_rx_timer: LIMIT must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         run_q <= 1'b0;
      end else if (start) begin
         cnt_q <= '0;
         run_q <= 1'b1;
      end else if (stop) begin
         cnt_q <= '0;
         run_q <= 1'b0;
      end else if (run_q) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign expire = run_q && (cnt_q == LAST);

   // R9: the frame logic stops the timer no later than its last count
   a_r9_timer_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      run_q |-> (cnt_q <= LAST));

endmodule

// File: rtl/slip_rx_frame.sv
module slip_rx_frame
   import slip_rx_pkg::*;
#(
   parameter int ADDR_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  dec_ev_t           ev,
   input  logic [ADDR_W-1:0] dev_addr,
   input  logic [7:0]        crc,
   input  logic              expire,
   output logic              crc_clr,
   output logic              crc_upd,
   output logic              tmr_start,
   output logic              tmr_stop,
   output logic              dec_flush,
   output logic              pld_valid,
   output logic [7:0]        pld_data,
   output logic              pld_sop,
   output logic              pld_eop,
   output logic              rep_valid,
   output logic [7:0]        rep_code
);

   localparam int HI_W = 8 - ADDR_W;

   frame_state_e st_q;
   logic [7:0]   hold_old, hold_new;
   logic [1:0]   hcnt_q;
   logic         first_q, bad_q;
   logic         addr_hit;

   assign addr_hit = (ev.val[7 -: HI_W] == '0) && (ev.val[ADDR_W-1:0] == dev_addr);

   always_comb begin
      crc_clr   = (st_q == FR_ADDR) && ev.data;
      tmr_start = (st_q == FR_ADDR) && ev.data && addr_hit;
      tmr_stop  = (st_q == FR_RX) && (ev.mark || expire);
      dec_flush = (st_q == FR_RX) && !ev.mark && expire;
      crc_upd   = (st_q == FR_RX) && !ev.mark && !expire && ev.data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= FR_IDLE;
         hold_old  <= '0;
         hold_new  <= '0;
         hcnt_q    <= '0;
         first_q   <= 1'b0;
         bad_q     <= 1'b0;
         pld_valid <= 1'b0;
         pld_data  <= '0;
         pld_sop   <= 1'b0;
         pld_eop   <= 1'b0;
         rep_valid <= 1'b0;
         rep_code  <= '0;
      end else begin
         pld_valid <= 1'b0;
         pld_sop   <= 1'b0;
         pld_eop   <= 1'b0;
         rep_valid <= 1'b0;
         unique case (st_q)
            FR_IDLE: if (ev.mark) st_q <= FR_ADDR;
            FR_ADDR: begin
               if (ev.mark) begin
                  st_q <= FR_ADDR;
               end else if (ev.data) begin
                  if (addr_hit) begin
                     st_q    <= FR_RX;
                     hcnt_q  <= '0;
                     first_q <= 1'b1;
                     bad_q   <= 1'b0;
                  end else begin
                     st_q <= FR_SKIP;
                  end
               end else if (ev.bad) begin
                  st_q <= FR_SKIP;
               end
            end
            FR_RX: begin
               if (ev.mark) begin
                  rep_valid <= 1'b1;
                  rep_code  <= (bad_q || ev.bad || hcnt_q == 2'd0 || crc != 8'h00)
                               ? RPL_NACK : RPL_ACK;
                  if (hcnt_q == 2'd2) begin
                     pld_valid <= 1'b1;
                     pld_data  <= hold_old;
                     pld_sop   <= first_q;
                     pld_eop   <= 1'b1;
                  end
                  st_q <= FR_IDLE;
               end else if (expire) begin
                  st_q <= FR_IDLE;
               end else begin
                  if (ev.data) begin
                     if (hcnt_q == 2'd2) begin
                        pld_valid <= 1'b1;
                        pld_data  <= hold_old;
                        pld_sop   <= first_q;
                        first_q   <= 1'b0;
                     end else begin
                        hcnt_q <= hcnt_q + 2'd1;
                     end
                     hold_old <= hold_new;
                     hold_new <= ev.val;
                  end
                  if (ev.bad) bad_q <= 1'b1;
               end
            end
            FR_SKIP: if (ev.mark) st_q <= FR_IDLE;
            default: st_q <= FR_IDLE;
         endcase
      end
   end

   // R6: only the two reply codes are ever requested
   a_r6_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
      rep_valid |-> (rep_code == RPL_ACK || rep_code == RPL_NACK));

   // R6: a reply is only produced when leaving an accepted frame
   a_r6_reply_from_rx: assert property (@(posedge clk) disable iff (!rst_n)
      rep_valid |-> ($past(st_q) == FR_RX && st_q == FR_IDLE));

   // R3: a frame for another device stays silent
   a_r3_skip_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == FR_SKIP) |=> (!pld_valid && !rep_valid));

   // R4: packet flags travel with a payload byte
   a_r4_flags_with_byte: assert property (@(posedge clk) disable iff (!rst_n)
      (pld_sop || pld_eop) |-> pld_valid);

endmodule

// File: rtl/slip_rx.sv
module slip_rx
   import slip_rx_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int ADDR_W      = 7,
   parameter int TIMEOUT_CYC = 25_000_000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   input  logic [ADDR_W-1:0] dev_addr,
   output logic              pld_valid,
   output logic [DATA_W-1:0] pld_data,
   output logic              pld_sop,
   output logic              pld_eop,
   output logic              rep_valid,
   output logic [DATA_W-1:0] rep_code
);

   localparam logic [7:0] CRC_POLY = 8'h07;

   if (DATA_W != 8) begin : g_bad_data_w
      $error("slip_rx: DATA_W must be 8");
   end
   if (ADDR_W < 1 || ADDR_W > DATA_W - 1) begin : g_bad_addr_w
      $error("slip_rx: ADDR_W must leave the top data bit free");
   end

   dec_ev_t    ev;
   logic [7:0] crc;
   logic       expire, crc_clr, crc_upd, tmr_start, tmr_stop, dec_flush;

   slip_rx_unstuff u_unstuff (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    (dec_flush),
      .in_valid (in_valid),
      .in_data  (in_data),
      .ev       (ev)
   );

   slip_rx_crc8 #(.W(8), .POLY(CRC_POLY)) u_crc (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (crc_clr),
      .upd   (crc_upd),
      .din   (ev.val),
      .crc   (crc)
   );

   slip_rx_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (tmr_start),
      .stop   (tmr_stop),
      .expire (expire)
   );

   slip_rx_frame #(.ADDR_W(ADDR_W)) u_frame (
      .clk       (clk),
      .rst_n     (rst_n),
      .ev        (ev),
      .dev_addr  (dev_addr),
      .crc       (crc),
      .expire    (expire),
      .crc_clr   (crc_clr),
      .crc_upd   (crc_upd),
      .tmr_start (tmr_start),
      .tmr_stop  (tmr_stop),
      .dec_flush (dec_flush),
      .pld_valid (pld_valid),
      .pld_data  (pld_data),
      .pld_sop   (pld_sop),
      .pld_eop   (pld_eop),
      .rep_valid (rep_valid),
      .rep_code  (rep_code)
   );

endmodule

// File: tb/test_slip_rx.sv
`timescale 1ns/1ps
module test_slip_rx;

   localparam int T = 200;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic [7:0] in_data = 8'h00;
   logic [6:0] dev_addr = 7'h07;
   logic       pld_valid, pld_sop, pld_eop, rep_valid;
   logic [7:0] pld_data, rep_code;

   slip_rx #(.TIMEOUT_CYC(T)) i_slip_rx (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .dev_addr(dev_addr), .pld_valid(pld_valid), .pld_data(pld_data),
      .pld_sop(pld_sop), .pld_eop(pld_eop), .rep_valid(rep_valid),
      .rep_code(rep_code)
   );

   always #2.5 clk = ~clk;

   int    checks = 0, fails = 0;
   string cur_req = "R10";
   int    n_ack = 0, n_nack = 0, n_byt = 0, n_eop = 0;
   int    s_ack, s_nack, s_byt, s_eop;

   // ---------------- reference model ----------------
   function automatic logic [7:0] crc_step(logic [7:0] c, logic [7:0] b);
      logic [7:0] r;
      r = c ^ b;
      for (int i = 0; i < 8; i++) r = r[7] ? ((r << 1) ^ 8'h07) : (r << 1);
      return r;
   endfunction

   int         mst = 0, mt = 0;
   bit         mesc = 0, mfirst = 0, mbad = 0;
   logic [7:0] mq[$];
   logic [7:0] mall[$];
   bit         e_pv = 0, e_sop = 0, e_eop = 0, e_rv = 0;
   logic [7:0] e_pd = 0, e_rc = 0;

   function void emit(logic [7:0] b, bit last);
      e_pv = 1; e_pd = b; e_sop = mfirst; e_eop = last; mfirst = 0;
   endfunction

   always @(posedge clk) begin
      bit ed, em, eb;
      logic [7:0] v, c;
      int n;
      e_pv = 0; e_sop = 0; e_eop = 0; e_rv = 0;
      if (!rst_n) begin
         mst = 0; mt = 0; mesc = 0; mq.delete(); mall.delete();
      end else begin
         ed = 0; em = 0; eb = 0; v = in_data;
         if (in_valid) begin
            if (mesc) begin
               mesc = 0;
               if (in_data == 8'hDC) begin ed = 1; v = 8'hC0; end
               else if (in_data == 8'hDD) begin ed = 1; v = 8'hDB; end
               else if (in_data == 8'hC0) begin em = 1; eb = 1; end
               else eb = 1;
            end else if (in_data == 8'hC0) em = 1;
            else if (in_data == 8'hDB) mesc = 1;
            else ed = 1;
         end
         case (mst)
            0: if (em) mst = 1;
            1: if (em) mst = 1;
               else if (ed) begin
                  if (v < 8'h80 && v[6:0] == dev_addr) begin
                     mst = 2; mt = 0; mq.delete(); mall.delete(); mfirst = 1; mbad = 0;
                  end else mst = 3;
               end else if (eb) mst = 3;
            2: if (em) begin
                  n = mall.size();
                  if (mq.size() == 2) emit(mq[0], 1);
                  c = 8'h00;
                  for (int i = 0; i < n - 1; i++) c = crc_step(c, mall[i]);
                  e_rv = 1;
                  e_rc = (mbad || eb || n == 0 || c != mall[n-1]) ? 8'h80 : 8'h00;
                  mst = 0;
               end else if (mt == T - 1) begin
                  mst = 0; mesc = 0;
               end else begin
                  mt++;
                  if (ed) begin
                     mq.push_back(v); mall.push_back(v);
                     if (mq.size() > 2) emit(mq.pop_front(), 0);
                  end
                  if (eb) mbad = 1;
               end
            3: if (em) mst = 0;
            default: mst = 0;
         endcase
      end
   end

   // ---------------- checking ----------------
   task automatic chk(string what, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s act=%0h exp=%0h at %0t", cur_req, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         chk("pld_valid", {7'd0, pld_valid}, {7'd0, e_pv});
         if (e_pv) begin
            chk("pld_data", pld_data, e_pd);
            chk("pld_sop", {7'd0, pld_sop}, {7'd0, e_sop});
            chk("pld_eop", {7'd0, pld_eop}, {7'd0, e_eop});
         end
         chk("rep_valid", {7'd0, rep_valid}, {7'd0, e_rv});
         if (e_rv) chk("rep_code", rep_code, e_rc);
         if (rep_valid) begin
            if (rep_code == 8'h00) n_ack++; else n_nack++;
         end
         if (pld_valid) n_byt++;
         if (pld_valid && pld_eop) n_eop++;
      end
   end

   task automatic scn(string req);
      cur_req = req;
      s_ack = n_ack; s_nack = n_nack; s_byt = n_byt; s_eop = n_eop;
   endtask

   task automatic tally(int a, int na, int b, int e);
      repeat (4) @(negedge clk);
      chk("ack count", 8'(n_ack - s_ack), 8'(a));
      chk("nack count", 8'(n_nack - s_nack), 8'(na));
      chk("byte count", 8'(n_byt - s_byt), 8'(b));
      chk("eop count", 8'(n_eop - s_eop), 8'(e));
   endtask

   // ---------------- stimulus ----------------
   task automatic put(logic [7:0] b, int gap);
      in_valid = 1'b1; in_data = b;
      @(negedge clk);
      in_valid = 1'b0;
      repeat (gap) @(negedge clk);
   endtask

   task automatic put_s(logic [7:0] b, int gap);
      if (b == 8'hC0) begin put(8'hDB, 0); put(8'hDC, gap); end
      else if (b == 8'hDB) begin put(8'hDB, 0); put(8'hDD, gap); end
      else put(b, gap);
   endtask

   task automatic send_pkt(logic [7:0] addr, logic [7:0] pl[$], bit corrupt, int gap);
      logic [7:0] c;
      c = 8'h00;
      put(8'hC0, gap);
      put_s(addr, gap);
      foreach (pl[i]) begin
         put_s(pl[i], gap);
         c = crc_step(c, pl[i]);
      end
      if (corrupt) c = c ^ 8'h01;
      put_s(c, gap);
      put(8'hC0, gap);
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog expired act=running exp=finished");
      finish_run();
   end

   initial begin
      logic [7:0] pl[$];
      logic [7:0] r;
      logic [7:0] hit;
      // R10: reset state
      repeat (3) @(negedge clk);
      chk("R10 pld_valid in reset", {7'd0, pld_valid}, 8'd0);
      chk("R10 rep_valid in reset", {7'd0, rep_valid}, 8'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10 pld_valid after reset", {7'd0, pld_valid}, 8'd0);
      chk("R10 flags after reset", {6'd0, pld_sop, pld_eop}, 8'd0);
      chk("R10 rep_valid after reset", {7'd0, rep_valid}, 8'd0);

      // R4 R5 R6: plain good frame
      scn("R4");
      pl = '{8'h11, 8'h22, 8'h33};
      send_pkt(8'h07, pl, 0, 0);
      tally(1, 0, 3, 1);

      // R2: escaped payload bytes
      scn("R2");
      pl = '{8'hC0, 8'hDB, 8'h55, 8'hDB};
      send_pkt(8'h07, pl, 0, 1);
      tally(1, 0, 4, 1);

      // R3: foreign address, and address with bit 7 set
      scn("R3");
      pl = '{8'h01, 8'h02};
      send_pkt(8'h08, pl, 0, 0);
      send_pkt(8'h87, pl, 0, 0);
      tally(0, 0, 0, 0);

      // R6: wrong check byte
      scn("R6");
      pl = '{8'hA0, 8'hB1, 8'hC2};
      send_pkt(8'h07, pl, 1, 0);
      tally(0, 1, 3, 1);

      // R7: illegal escape pair, then escape before closing marker
      scn("R7");
      put(8'hC0, 0); put(8'h07, 0); put(8'h11, 0); put(8'hDB, 0); put(8'h41, 0);
      put(8'h22, 0); put(8'h5E, 0); put(8'hC0, 0);
      put(8'hC0, 0); put(8'h07, 0); put(8'h11, 0); put(8'hDB, 0); put(8'hC0, 0);
      tally(0, 2, 2, 1);

      // R1: stray bytes outside a frame and repeated markers
      scn("R1");
      put(8'h33, 0); put(8'h44, 0);
      put(8'hC0, 0); put(8'hC0, 0);
      pl = '{8'hA1};
      send_pkt(8'h07, pl, 0, 0);
      tally(1, 0, 1, 1);

      // R8: empty payload is accepted, missing check byte is rejected
      scn("R8");
      put(8'hC0, 0); put(8'h07, 0); put(8'h00, 0); put(8'hC0, 0);
      put(8'hC0, 0); put(8'h07, 0); put(8'hC0, 0);
      tally(1, 1, 0, 0);

      // R9: abandoned frame, then a normal one
      scn("R9");
      put(8'hC0, 0); put(8'h07, 0); put(8'h11, 0); put(8'h22, 0); put(8'h33, T + 5);
      put(8'hC0, 0);
      pl = '{8'h5A};
      send_pkt(8'h07, pl, 0, 0);
      tally(1, 0, 2, 1);

      // R9: closing marker on the last allowed edge, then one edge late
      scn("R9");
      put(8'hC0, 0); put(8'h07, 0); put(8'h00, T - 2); put(8'hC0, 0);
      put(8'hC0, 0); put(8'h07, 0); put(8'h00, T - 1); put(8'hC0, 0);
      tally(1, 0, 0, 0);

      // R4: long payload with gaps, and back-to-back frames
      scn("R4");
      pl.delete();
      r = 8'h5A;
      for (int i = 0; i < 20; i++) begin
         r = {r[6:0], r[7] ^ r[5] ^ r[4] ^ r[3]};
         pl.push_back(r);
      end
      send_pkt(8'h07, pl, 0, 2);
      pl = '{8'h01, 8'h02};
      send_pkt(8'h07, pl, 0, 0);
      send_pkt(8'h07, pl, 0, 0);
      tally(3, 0, 24, 3);

      // R3: address extremes
      scn("R3");
      dev_addr = 7'h7F;
      pl = '{8'h42};
      send_pkt(8'h7F, pl, 0, 0);
      send_pkt(8'hFF, pl, 0, 0);
      dev_addr = 7'h00;
      send_pkt(8'h00, pl, 0, 0);
      tally(2, 0, 2, 2);

      // R2 R5: check byte that itself needs escaping
      scn("R5");
      dev_addr = 7'h07;
      hit = 8'h00;
      for (int b = 0; b < 256; b++)
         if (crc_step(8'h00, 8'(b)) == 8'hC0) hit = 8'(b);
      pl = '{hit};
      send_pkt(8'h07, pl, 0, 0);
      for (int b = 0; b < 256; b++)
         if (crc_step(8'h00, 8'(b)) == 8'hDB) hit = 8'(b);
      pl = '{hit};
      send_pkt(8'h07, pl, 0, 0);
      tally(2, 0, 2, 2);

      finish_run();
   end

endmodule